// File: doc/BRIEF.md
# Descriptor-Chained Audio DMA Channel

This block is one bus-master channel that moves audio sample words between system memory and a codec-side sample port. Software builds a table of descriptors in memory, writes the table address into the channel, and starts it through a command register. The channel reads each descriptor, then moves the region it describes. In playback it copies memory words to the sample output port. In capture it copies sample input words into memory. When a descriptor flagged for it completes, the channel latches an end-of-page status and raises its interrupt. A jump descriptor sends the channel back to any table address, so a table whose last entry jumps to its own start forms an endless ring buffer.

Software controls the channel with three commands: run, pause and stop. It can choose big-endian byte order per word. It reads back the address of the data word currently in flight. The interrupt appears on a dedicated line and also as one bit of a shared interrupt word. The position of that bit depends on the channel number, so several channels can be ORed into one status word.

Top module: `audio_prd_dma`

## Requirements
- R1: After reset, the command, status, table-address and pointer registers read 0, `irq` and `irq_word` are 0, and `mem_req` is low.
- R2: A descriptor is two words: the region base address at table offset +0 and a size word at +4. Size bits [15:0] are the byte count, and the two low bits are ignored. Bit 31 flags end of table, bit 30 flags end of page and bit 29 flags a jump. In playback, region words appear on `out_data` in ascending address order, and consecutive descriptors are taken at 8-byte steps.
- R3: When a descriptor with the end-of-page flag finishes, status bit 0 (register offset 1) sets, `irq` goes high, and `irq_word` bit CHAN_ID+2 goes high while every other bit stays 0.
- R4: A read of the status register returns its value and then clears bits 1:0. `irq` is low from the next cycle unless a new event arrives in the same cycle.
- R5: A descriptor with the jump flag moves no data. The channel reloads its descriptor pointer from that descriptor's base word, so a table can loop without end.
- R6: When an end-of-table descriptor without a jump finishes, the command control field (offset 0, bits 1:0) reads 00 and the channel issues no further memory requests.
- R7: Control value 11 pauses the channel. No new memory request starts, `out_valid` and `in_ready` are low, and the pointer holds its value. Writing 01 resumes exactly at the next word.
- R8: Command bit 3 = 1 selects capture: words accepted on `in_data` are written to consecutive memory words of the region.
- R9: Command bit 2 = 1 selects big-endian order: the four bytes of every data word are reversed between memory and the sample port, in both directions.
- R10: When a memory access returns `mem_err`, status bit 1 sets at the completion of the next end-of-page descriptor.
- R11: Control value 00 written mid-buffer stops the channel once any pending memory access is acknowledged. Writing 01 afterwards restarts from the table address.
- R12: The pointer register (offset 3) reads the byte address of the data word being moved. It advances by 4 after each word completes on the sample port (playback) or in memory (capture).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (needed for read-clear of status) |
| reg_addr | input | 2 | Register select: 0 command, 1 status, 2 table address, 3 pointer |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| mem_req | output | 1 | Memory access request, held until `mem_ack` |
| mem_we | output | 1 | 1 for a memory write, 0 for a read |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access completes this cycle |
| mem_err | input | 1 | Access completed with an error, valid with `mem_ack` |
| out_valid | output | 1 | Playback word available |
| out_data | output | 32 | Playback sample word |
| out_ready | input | 1 | Sink accepts the playback word |
| in_valid | input | 1 | Capture word offered |
| in_data | input | 32 | Capture sample word |
| in_ready | output | 1 | Channel accepts the capture word |
| irq | output | 1 | Channel interrupt: any status bit set |
| irq_word | output | 16 | Shared interrupt word with this channel's bit at CHAN_ID+2 |

## Verification
A wrong descriptor pointer or region address appears at once on the sample port. The words arrive out of order, repeat, or come from the wrong region, and comparing each word against the expected memory content catches it within the first descriptor. A lost flag shows up at the end of a buffer: the control field is still running after an end-of-table entry, or status and `irq` stay low after an end-of-page entry. Pause and stop faults leave the pointer register moving or memory requests appearing during a quiet window of tens of cycles. The bench counts those requests at the port.

// File: rtl/prd_dma_pkg.sv
// Shared definitions for the descriptor-chained audio DMA channel.
// Assumes 32-bit descriptor words; flag positions are fixed by the table format.
package prd_dma_pkg;

    localparam int FLAG_EOT = 31;
    localparam int FLAG_EOP = 30;
    localparam int FLAG_JMP = 29;

    localparam logic [1:0] RA_CMD  = 2'd0;
    localparam logic [1:0] RA_STAT = 2'd1;
    localparam logic [1:0] RA_TBL  = 2'd2;
    localparam logic [1:0] RA_PTR  = 2'd3;

    typedef enum logic [1:0] {
        CTL_OFF  = 2'b00,
        CTL_RUN  = 2'b01,
        CTL_RSV  = 2'b10,
        CTL_HOLD = 2'b11
    } ctl_e;

    typedef struct packed {
        logic dir;
        logic swap;
        ctl_e ctl;
    } cmd_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_GETBASE,
        S_GETSIZE,
        S_RDMEM,
        S_PUSH,
        S_PULL,
        S_WRMEM,
        S_DONE
    } st_e;

endpackage

// File: rtl/prd_dma_swap.sv
// Byte-lane reverser for one data word.
// Assumes the width is a whole number of bytes; purely combinational.
module prd_dma_swap #(
    parameter int W = 32
) (
    input  logic         swap_en,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] data_o
);
    localparam int NB = W / 8;

    // one mux per byte lane: straight or mirrored
    for (genvar i = 0; i < NB; i++) begin : g_lane
        assign data_o[8*i +: 8] = swap_en ? data_i[8*(NB-1-i) +: 8] : data_i[8*i +: 8];
    end
endmodule

// File: rtl/prd_dma_regs.sv
// Software-visible registers of the channel: command, status, table address
// and pointer readback. Status bits are sticky until a status read.
// Assumes a single-cycle read strobe per read; a software command write in the
// same cycle as an engine stop takes precedence.
module prd_dma_regs
    import prd_dma_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [1:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output cmd_t          cmd,
    output logic [AW-1:0] tbl_base,
    input  logic          eng_stop,
    input  logic          set_eop,
    input  logic          set_err,
    input  logic [AW-1:0] cur_ptr,
    output logic          irq
);
    logic [1:0] stat;
    logic       rd_stat;
    logic       wr_cmd;

    assign rd_stat = reg_rd && (reg_addr == RA_STAT);
    assign wr_cmd  = reg_wr && (reg_addr == RA_CMD);

    // command and table-address registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd      <= '0;
            tbl_base <= '0;
        end else begin
            if (eng_stop) cmd.ctl <= CTL_OFF;
            if (wr_cmd) cmd <= cmd_t'(reg_wdata[3:0]);
            if (reg_wr && (reg_addr == RA_TBL)) tbl_base <= reg_wdata[AW-1:0];
        end
    end

    // sticky status with clear-on-read; a new event wins over the clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat <= '0;
        end else begin
            if (rd_stat) stat <= '0;
            if (set_eop) stat[0] <= 1'b1;
            if (set_err) stat[1] <= 1'b1;
        end
    end

    // read mux
    always_comb begin
        unique case (reg_addr)
            RA_CMD:  reg_rdata = {28'd0, cmd};
            RA_STAT: reg_rdata = {30'd0, stat};
            RA_TBL:  reg_rdata = 32'(tbl_base);
            default: reg_rdata = 32'(cur_ptr);
        endcase
    end

    assign irq = |stat;

    assert_eop_sets_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
        set_eop |=> stat[0] && irq);

    assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && !set_eop && !set_err) |=> (stat == 2'b00) && !irq);

    assert_stop_clears_ctl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_stop && !wr_cmd) |=> (cmd.ctl == CTL_OFF));

    assert_err_reported_R10: assert property (@(posedge clk) disable iff (!rst_n)
        set_err |=> stat[1]);
endmodule

// File: rtl/prd_dma_engine.sv
// Descriptor walker and data mover for one channel.
// Fetches base and size words, follows jump entries, moves one word at a time
// through a single holding register, and reports page/table completion.
// Assumes a request is held with a stable address until acknowledged, and that
// pause and stop act only between memory accesses.
module prd_dma_engine
    import prd_dma_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int CNT_W = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ctl_e          ctl,
    input  logic          dir,
    input  logic [AW-1:0] tbl_base,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ack,
    input  logic          mem_err,
    output logic          out_valid,
    output logic [DW-1:0] out_word,
    input  logic          out_ready,
    input  logic          in_valid,
    input  logic [DW-1:0] in_word,
    output logic          in_ready,
    output logic          set_eop,
    output logic          set_err,
    output logic          eng_stop,
    output logic [AW-1:0] cur_ptr
);
    localparam int               STEP   = DW / 8;
    localparam logic [CNT_W-1:0] STEP_C = CNT_W'(STEP);
    localparam logic [AW-1:0]    STEP_A = AW'(STEP);
    localparam logic [AW-1:0]    DESC_A = AW'(2 * STEP);

    st_e              st;
    logic [AW-1:0]    desc_ptr;
    logic [AW-1:0]    cur_addr;
    logic [CNT_W-1:0] rem;
    logic [DW-1:0]    hold;
    logic             req_q;
    logic             eop_f;
    logic             eot_f;
    logic             err_pend;
    logic             go;
    logic             halt;
    logic [CNT_W-1:0] size_bytes;

    assign go         = (ctl == CTL_RUN);
    assign halt       = (ctl == CTL_OFF);
    assign size_bytes = mem_rdata[CNT_W-1:0] & ~(STEP_C - 1'b1);

    // address and data presented to memory for the current access
    always_comb begin
        unique case (st)
            S_GETBASE: mem_addr = desc_ptr;
            S_GETSIZE: mem_addr = desc_ptr + STEP_A;
            default:   mem_addr = cur_addr;
        endcase
    end

    assign mem_req   = req_q;
    assign mem_we    = (st == S_WRMEM);
    assign mem_wdata = hold;
    assign out_word  = hold;
    assign out_valid = (st == S_PUSH) && go;
    assign in_ready  = (st == S_PULL) && go;
    assign set_eop   = (st == S_DONE) && eop_f;
    assign set_err   = set_eop && err_pend;
    assign eng_stop  = (st == S_DONE) && eot_f;
    assign cur_ptr   = cur_addr;

    // channel sequencer: descriptor fetch, word transfer, completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= S_IDLE;
            desc_ptr <= '0;
            cur_addr <= '0;
            rem      <= '0;
            hold     <= '0;
            req_q    <= 1'b0;
            eop_f    <= 1'b0;
            eot_f    <= 1'b0;
            err_pend <= 1'b0;
        end else begin
            unique case (st)
                S_IDLE: begin
                    if (go) begin
                        desc_ptr <= tbl_base;
                        err_pend <= 1'b0;
                        st       <= S_GETBASE;
                    end
                end
                S_GETBASE, S_GETSIZE, S_RDMEM, S_WRMEM: begin
                    if (!req_q) begin
                        if (halt)    st    <= S_IDLE;
                        else if (go) req_q <= 1'b1;
                    end else if (mem_ack) begin
                        req_q <= 1'b0;
                        if (mem_err) err_pend <= 1'b1;
                        case (st)
                            S_GETBASE: begin
                                cur_addr <= mem_rdata[AW-1:0];
                                st       <= S_GETSIZE;
                            end
                            S_GETSIZE: begin
                                eop_f <= mem_rdata[FLAG_EOP];
                                eot_f <= mem_rdata[FLAG_EOT];
                                if (mem_rdata[FLAG_JMP]) begin
                                    desc_ptr <= cur_addr;
                                    st       <= S_GETBASE;
                                end else if (size_bytes == '0) begin
                                    st <= S_DONE;
                                end else begin
                                    rem <= size_bytes;
                                    st  <= dir ? S_PULL : S_RDMEM;
                                end
                            end
                            S_RDMEM: begin
                                hold <= mem_rdata;
                                st   <= S_PUSH;
                            end
                            default: begin
                                cur_addr <= cur_addr + STEP_A;
                                rem      <= rem - STEP_C;
                                st       <= (rem == STEP_C) ? S_DONE : S_PULL;
                            end
                        endcase
                    end
                end
                S_PUSH: begin
                    if (halt) begin
                        st <= S_IDLE;
                    end else if (go && out_ready) begin
                        cur_addr <= cur_addr + STEP_A;
                        rem      <= rem - STEP_C;
                        st       <= (rem == STEP_C) ? S_DONE : S_RDMEM;
                    end
                end
                S_PULL: begin
                    if (halt) begin
                        st <= S_IDLE;
                    end else if (go && in_valid) begin
                        hold <= in_word;
                        st   <= S_WRMEM;
                    end
                end
                S_DONE: begin
                    if (eop_f) err_pend <= 1'b0;
                    if (eot_f) begin
                        st <= S_IDLE;
                    end else begin
                        desc_ptr <= desc_ptr + DESC_A;
                        st       <= S_GETBASE;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    assert_data_count_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st inside {S_RDMEM, S_PUSH, S_PULL, S_WRMEM}) |-> (rem != '0));

    assert_pause_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl == CTL_HOLD && !mem_req) |=> !mem_req && $stable(cur_ptr));

    assert_idle_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE) |-> !mem_req && !out_valid && !in_ready);
endmodule

// File: rtl/audio_prd_dma.sv
// Top of one descriptor-chained audio DMA channel: registers, engine, and the
// byte-order stage on both sample directions, plus the shared interrupt bit.
// Assumes CHAN_ID + 2 < IRQW and 32-bit data and descriptor words.
module audio_prd_dma #(
    parameter int CHAN_ID = 0,
    parameter int IRQW    = 16,
    parameter int AW      = 32,
    parameter int CNT_W   = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic            reg_rd,
    input  logic [1:0]      reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [31:0]     mem_wdata,
    input  logic [31:0]     mem_rdata,
    input  logic            mem_ack,
    input  logic            mem_err,
    output logic            out_valid,
    output logic [31:0]     out_data,
    input  logic            out_ready,
    input  logic            in_valid,
    input  logic [31:0]     in_data,
    output logic            in_ready,
    output logic            irq,
    output logic [IRQW-1:0] irq_word
);
    import prd_dma_pkg::*;

    localparam int DW      = 32;
    localparam int IRQ_BIT = CHAN_ID + 2;

    cmd_t          cmd;
    logic [AW-1:0] tbl_base;
    logic [AW-1:0] cur_ptr;
    logic          eng_stop;
    logic          set_eop;
    logic          set_err;
    logic [DW-1:0] out_raw;
    logic [DW-1:0] in_swapped;

    prd_dma_regs #(.AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cmd       (cmd),
        .tbl_base  (tbl_base),
        .eng_stop  (eng_stop),
        .set_eop   (set_eop),
        .set_err   (set_err),
        .cur_ptr   (cur_ptr),
        .irq       (irq)
    );

    prd_dma_engine #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (cmd.ctl),
        .dir       (cmd.dir),
        .tbl_base  (tbl_base),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ack   (mem_ack),
        .mem_err   (mem_err),
        .out_valid (out_valid),
        .out_word  (out_raw),
        .out_ready (out_ready),
        .in_valid  (in_valid),
        .in_word   (in_swapped),
        .in_ready  (in_ready),
        .set_eop   (set_eop),
        .set_err   (set_err),
        .eng_stop  (eng_stop),
        .cur_ptr   (cur_ptr)
    );

    prd_dma_swap #(.W(DW)) u_swap_out (
        .swap_en (cmd.swap),
        .data_i  (out_raw),
        .data_o  (out_data)
    );

    prd_dma_swap #(.W(DW)) u_swap_in (
        .swap_en (cmd.swap),
        .data_i  (in_data),
        .data_o  (in_swapped)
    );

    // place the channel interrupt at its slot in the shared word
    for (genvar b = 0; b < IRQW; b++) begin : g_irq
        assign irq_word[b] = (b == IRQ_BIT) ? irq : 1'b0;
    end

    assert_irq_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(irq_word) == (irq ? 1 : 0));
endmodule

// File: tb/audio_prd_dma_tb.sv
`timescale 1ns/1ps
module audio_prd_dma_tb;
    localparam int CH = 1;
    localparam logic [31:0] F_EOT = 32'h8000_0000;
    localparam logic [31:0] F_EOP = 32'h4000_0000;
    localparam logic [31:0] F_JMP = 32'h2000_0000;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0, reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = 32'd0;
    logic        mem_ack = 1'b0, mem_err = 1'b0;
    logic        out_valid;
    logic [31:0] out_data;
    logic        out_ready = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = 32'd0;
    logic        in_ready, irq;
    logic [15:0] irq_word;

    audio_prd_dma #(.CHAN_ID(CH)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .mem_err(mem_err), .out_valid(out_valid), .out_data(out_data),
        .out_ready(out_ready), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .irq(irq), .irq_word(irq_word)
    );

    int checks = 0, fails = 0, cyc = 0;
    logic [31:0] mem [0:1023];
    logic [31:0] err_addr = 32'hFFFF_FFFF;
    logic [31:0] out_log [0:255];
    int out_n = 0;
    bit ready_block = 1'b0, throttle = 1'b1;
    logic [31:0] cap_words [0:15];
    int cap_n = 0, cap_i = 0;
    bit cap_hs = 1'b0;
    int req_cnt = 0;

    function automatic logic [31:0] swap32(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // one negedge of the memory model, sample sink, sample source and watchdog
    task automatic step();
        cyc++;
        if (cyc > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%h expected=%h", cyc, 150000);
            summary();
        end
        if (mem_ack) begin
            mem_ack = 1'b0; mem_err = 1'b0;
        end else if (mem_req && ($urandom % 3 != 0)) begin
            mem_ack = 1'b1;
            mem_err = (mem_addr == err_addr);
            if (mem_we) mem[mem_addr[11:2]] = mem_wdata;
            else        mem_rdata = mem[mem_addr[11:2]];
        end
        out_ready = ready_block ? 1'b0 : (throttle ? ($urandom % 4 != 0) : 1'b1);
        if (out_valid && out_ready && out_n < 256) begin
            out_log[out_n] = out_data; out_n++;
        end
        if (cap_hs) cap_i++;
        in_data  = cap_words[cap_i];
        in_valid = (cap_i < cap_n) && ($urandom % 4 != 0);
        cap_hs   = in_valid && in_ready;
        if (mem_req) req_cnt++;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic wait_off(input string req);
        logic [31:0] d;
        for (int k = 0; k < 4000; k++) begin
            rd(2'd0, d);
            if (d[1:0] == 2'b00) return;
        end
        chk(1'b0, req, d, 32'd0);
    endtask

    task automatic wait_outs(input int n);
        for (int k = 0; k < 4000 && out_n < n; k++) @(negedge clk);
    endtask

    task automatic put_desc(input logic [31:0] at, input logic [31:0] base, input logic [31:0] sz);
        mem[at[11:2]] = base;
        mem[at[11:2] + 1] = sz;
    endtask

    initial begin
        logic [31:0] d;
        int b, q0, r0;
        void'($urandom(32'd20240513));
        for (int i = 0; i < 1024; i++) mem[i] = $urandom;
        fork
            forever begin @(negedge clk); step(); end
        join_none

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rd(2'd0, d); chk(d == 0, "R1 cmd", d, 0);
        rd(2'd1, d); chk(d == 0, "R1 status", d, 0);
        rd(2'd2, d); chk(d == 0, "R1 table", d, 0);
        rd(2'd3, d); chk(d == 0, "R1 pointer", d, 0);
        chk(!irq && irq_word == 0 && !mem_req, "R1 irq/req", {irq_word, 15'd0, irq}, 0);

        // R2 R3 R6: two-descriptor playback ending at end of table
        put_desc(32'h100, 32'h400, 16 | F_EOP);
        put_desc(32'h108, 32'h500, 8 | F_EOP | F_EOT);
        b = out_n;
        wr(2'd2, 32'h100); wr(2'd0, 32'h1);
        wait_off("R6 stop at end of table");
        chk(out_n - b == 6, "R2 word count", out_n - b, 6);
        for (int i = 0; i < 6; i++) begin
            d = (i < 4) ? mem[(32'h400 >> 2) + i] : mem[(32'h500 >> 2) + i - 4];
            chk(out_log[b + i] == d, "R2 playback word", out_log[b + i], d);
        end
        chk(irq == 1'b1, "R3 irq", irq, 1);
        chk(irq_word == 16'(1 << (CH + 2)), "R3 irq_word slot", irq_word, 16'(1 << (CH + 2)));
        q0 = req_cnt; repeat (20) @(negedge clk);
        chk(req_cnt == q0, "R6 no requests after end", req_cnt - q0, 0);
        rd(2'd1, d); chk(d == 32'd1, "R3 status bit0", d, 1);
        @(negedge clk);
        chk(irq == 1'b0, "R4 irq cleared by read", irq, 0);
        rd(2'd1, d); chk(d == 0, "R4 status cleared", d, 0);

        // R5: jump loops the table
        put_desc(32'h180, 32'h600, 8 | F_EOP);
        put_desc(32'h188, 32'h180, F_JMP);
        b = out_n;
        wr(2'd2, 32'h180); wr(2'd0, 32'h1);
        wait_outs(b + 6);
        wr(2'd0, 32'h0);
        for (int i = 0; i < 6; i++) begin
            d = mem[(32'h600 >> 2) + (i % 2)];
            chk(out_log[b + i] == d, "R5 looped word", out_log[b + i], d);
        end
        repeat (10) @(negedge clk);
        q0 = req_cnt; r0 = out_n; repeat (20) @(negedge clk);
        chk(req_cnt == q0 && out_n == r0, "R11 quiet after stop", req_cnt - q0, 0);
        rd(2'd1, d);

        // R7 R12: pause mid-buffer, pointer holds, resume exactly
        put_desc(32'h200, 32'h700, 32 | F_EOP | F_EOT);
        b = out_n;
        wr(2'd2, 32'h200); wr(2'd0, 32'h1);
        wait_outs(b + 3);
        ready_block = 1'b1;
        repeat (2) @(negedge clk);
        wr(2'd0, 32'h3);
        ready_block = 1'b0;
        repeat (10) @(negedge clk);
        q0 = req_cnt; r0 = out_n;
        repeat (20) @(negedge clk);
        chk(out_n == r0, "R7 no output while paused", out_n - r0, 0);
        chk(req_cnt == q0, "R7 no requests while paused", req_cnt - q0, 0);
        rd(2'd3, d);
        chk(d == 32'h700 + 4 * (r0 - b), "R12 pointer at paused word", d, 32'h700 + 4 * (r0 - b));
        wr(2'd0, 32'h1);
        wait_off("R7 resume to end");
        chk(out_n - b == 8, "R7 total words", out_n - b, 8);
        for (int i = 0; i < 8; i++) begin
            d = mem[(32'h700 >> 2) + i];
            chk(out_log[b + i] == d, "R7 resumed order", out_log[b + i], d);
        end
        rd(2'd3, d); chk(d == 32'h720, "R12 pointer after last word", d, 32'h720);
        rd(2'd1, d);

        // R8: capture little-endian
        for (int i = 0; i < 4; i++) cap_words[i] = $urandom;
        cap_i = 0; cap_hs = 1'b0; cap_n = 4;
        put_desc(32'h280, 32'h800, 16 | F_EOP | F_EOT);
        wr(2'd2, 32'h280); wr(2'd0, 32'h9);
        wait_off("R8 capture end");
        for (int i = 0; i < 4; i++)
            chk(mem[(32'h800 >> 2) + i] == cap_words[i], "R8 captured word", mem[(32'h800 >> 2) + i], cap_words[i]);
        cap_n = 0;
        rd(2'd1, d);

        // R9: capture big-endian
        for (int i = 0; i < 2; i++) cap_words[i] = $urandom;
        cap_i = 0; cap_hs = 1'b0; cap_n = 2;
        put_desc(32'h2C0, 32'h900, 8 | F_EOP | F_EOT);
        wr(2'd2, 32'h2C0); wr(2'd0, 32'hD);
        wait_off("R9 capture end");
        for (int i = 0; i < 2; i++)
            chk(mem[(32'h900 >> 2) + i] == swap32(cap_words[i]), "R9 swapped capture", mem[(32'h900 >> 2) + i], swap32(cap_words[i]));
        cap_n = 0;
        rd(2'd1, d);

        // R9: playback big-endian
        put_desc(32'h2E0, 32'hA00, 8 | F_EOP | F_EOT);
        b = out_n;
        wr(2'd2, 32'h2E0); wr(2'd0, 32'h5);
        wait_off("R9 playback end");
        for (int i = 0; i < 2; i++) begin
            d = swap32(mem[(32'hA00 >> 2) + i]);
            chk(out_log[b + i] == d, "R9 swapped playback", out_log[b + i], d);
        end
        rd(2'd1, d);

        // R10: memory error reported with end of page
        put_desc(32'h300, 32'hB00, 8 | F_EOP);
        put_desc(32'h308, 32'hB80, 4 | F_EOP | F_EOT);
        err_addr = 32'hB04;
        wr(2'd2, 32'h300); wr(2'd0, 32'h1);
        wait_off("R10 end");
        err_addr = 32'hFFFF_FFFF;
        rd(2'd1, d); chk(d == 32'd3, "R10 error and page bits", d, 3);
        rd(2'd1, d); chk(d == 0, "R4 cleared after error", d, 0);

        // R11: stop mid-buffer, restart from table start
        put_desc(32'h380, 32'hC00, 32 | F_EOP | F_EOT);
        b = out_n;
        ready_block = 1'b1;
        wr(2'd2, 32'h380); wr(2'd0, 32'h1);
        repeat (20) @(negedge clk);
        wr(2'd0, 32'h0);
        ready_block = 1'b0;
        repeat (10) @(negedge clk);
        q0 = req_cnt; repeat (20) @(negedge clk);
        chk(req_cnt == q0 && out_n == b, "R11 stopped", req_cnt - q0 + out_n - b, 0);
        wr(2'd0, 32'h1);
        wait_off("R11 restart end");
        chk(out_n - b == 8, "R11 restart count", out_n - b, 8);
        for (int i = 0; i < 8; i++) begin
            d = mem[(32'hC00 >> 2) + i];
            chk(out_log[b + i] == d, "R11 restart word", out_log[b + i], d);
        end

        summary();
    end
endmodule